// File: doc/BRIEF.md
# Cycle-Timed Synchronisation Loop Close Sequencer

This block orders the start-up of a synchronisation loop that is designed to lock onto harmonics of its reference. Within each machine cycle it counts milliseconds from the cycle-start event. At the calibration-stop event it gives the loop's oscillator its initial frequency word through a one-cycle load strobe, and the loop stays open. The loop is closed only when the millisecond count reaches a programmed close time. That time is set a few milliseconds ahead of injection, so that the phase can settle while the reference is already at its final value. Because the loop is open while the reference sweeps upward, it cannot lock onto a wrong harmonic.

Software writes two registers. The first is a staging copy of the initial frequency word. It is double-buffered and moves into the active word only at a cycle start. The second is the close time, which takes effect as soon as it is written. The loop is forced open at the end of each cycle and again at the next cycle start. All per-cycle state is re-armed at cycle start, so back-to-back cycles work. If the close time arrives before any frequency has been loaded, the loop stays open and a sticky error output is raised.

Top module: `loop_close_seq`

## Requirements
- R1: After reset, `loop_en`, `freq_load` and `seq_err` are 0 and `freq_word` is 0.
- R2: `cyc_start` clears the millisecond count. Each `ms_tick` then adds one to the count, which saturates at its maximum. The close time is measured from the most recent `cyc_start`.
- R3: A `cal_stop` pulse inside a cycle gives `freq_load` high for exactly one clock, in the clock after the pulse. `loop_en` stays 0 until the close time.
- R4: `cal_stop` has no effect on `freq_load` outside a cycle, meaning after `cyc_end` and before the next `cyc_start`. It also has no effect after the first load of the current cycle.
- R5: When frequency has been loaded, `loop_en` goes to 1 in the clock after the `ms_tick` that brings the count equal to the close-time register. An example is the 5th tick after `cyc_start` for a close time of 5. `loop_en` stays 0 before that tick.
- R6: The close-time match is taken at most once per cycle and never outside a cycle. Once it has been taken, rewriting the close time and ticking again cannot close the loop in that cycle.
- R7: `cyc_end` and `cyc_start` each force `loop_en` to 0 in the following clock.
- R8: If the match occurs before any `cal_stop` load in that cycle, `loop_en` stays 0 and `seq_err` goes to 1. `seq_err` remains 1 until reset.
- R9: A write with `wr_sel`=0 stores `wr_data` in the staging frequency register. `freq_word` takes the staged value only in the clock after the next `cyc_start`.
- R10: A write with `wr_sel`=1 loads `wr_data[CNT_W-1:0]` into the close-time register, and it applies to the very next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-clock pulse per millisecond |
| cyc_start | input | 1 | Machine cycle start event |
| cal_stop | input | 1 | Calibration stop event |
| cyc_end | input | 1 | Machine cycle end event |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = staging frequency word, 1 = close time |
| wr_data | input | 32 | Write data |
| freq_load | output | 1 | Oscillator frequency load strobe |
| freq_word | output | 32 | Active initial frequency word |
| loop_en | output | 1 | Loop closed when 1 |
| seq_err | output | 1 | Sticky: close time reached before frequency load |

## Verification
The assertions check, on every clock, the rules that relate events to outputs:
- a load strobe only follows a calibration-stop;
- the loop closes only straight after a millisecond tick;
- either cycle boundary opens the loop;
- the error flag never drops;
- the frequency word changes only after a cycle start.

Only the bench scenarios can show the quantities that depend on counting and on history:
- the exact tick on which the loop closes;
- the counter restarting on back-to-back cycles;
- the single-match rule after a rewrite of the close time;
- a second or out-of-cycle calibration-stop being ignored;
- the double buffering of the frequency word.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  localparam int unsigned FREQ_W = 32;
  localparam int unsigned CNT_W  = 16;
  typedef logic [FREQ_W-1:0] freq_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/lcs_ms_counter.sv
module lcs_ms_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] cnt_after
);
  localparam logic [W-1:0] MAXV = '1;
  logic [W-1:0] cnt_q, cnt_d;

  // value the count takes once the current tick is applied
  assign cnt_after = (cnt_q == MAXV) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = cnt_after;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lcs_freq_buffer.sv
module lcs_freq_buffer #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         swap,
  output logic [W-1:0] active
);
  logic [W-1:0] stage_q, stage_d, act_q, act_d;

  always_comb begin
    stage_d = wr   ? wdata   : stage_q;
    act_d   = swap ? stage_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      stage_q <= stage_d;
      act_q   <= act_d;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/lcs_close_ctrl.sv
module lcs_close_ctrl #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cyc_start,
  input  logic         cyc_end,
  input  logic         cal_stop,
  input  logic         tick,
  input  logic [W-1:0] cnt_after,
  input  logic         ct_wr,
  input  logic [W-1:0] ct_wdata,
  output logic         load_pulse,
  output logic         loop_en,
  output logic         err
);
  logic [W-1:0] ct_q, ct_d;
  logic in_cyc_q, in_cyc_d, loaded_q, loaded_d, matched_q, matched_d;
  logic load_q, load_d, en_q, en_d, err_q, err_d;
  logic hit;

  assign hit = tick && in_cyc_q && !matched_q && (cnt_after == ct_q);

  always_comb begin
    ct_d      = ct_wr ? ct_wdata : ct_q;
    in_cyc_d  = in_cyc_q;
    loaded_d  = loaded_q;
    matched_d = matched_q;
    load_d    = 1'b0;
    en_d      = en_q;
    err_d     = err_q;
    if (cyc_start) begin
      in_cyc_d  = 1'b1;
      loaded_d  = 1'b0;
      matched_d = 1'b0;
      en_d      = 1'b0;
    end else if (cyc_end) begin
      in_cyc_d  = 1'b0;
      en_d      = 1'b0;
    end else begin
      if (cal_stop && in_cyc_q && !loaded_q) begin
        load_d   = 1'b1;
        loaded_d = 1'b1;
      end
      if (hit) begin
        matched_d = 1'b1;
        if (loaded_q) en_d  = 1'b1;
        else          err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ct_q      <= '0;
      in_cyc_q  <= 1'b0;
      loaded_q  <= 1'b0;
      matched_q <= 1'b0;
      load_q    <= 1'b0;
      en_q      <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      ct_q      <= ct_d;
      in_cyc_q  <= in_cyc_d;
      loaded_q  <= loaded_d;
      matched_q <= matched_d;
      load_q    <= load_d;
      en_q      <= en_d;
      err_q     <= err_d;
    end
  end

  assign load_pulse = load_q;
  assign loop_en    = en_q;
  assign err        = err_q;
endmodule

// File: rtl/loop_close_seq.sv
module loop_close_seq
  import lcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              cyc_start,
  input  logic              cal_stop,
  input  logic              cyc_end,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [FREQ_W-1:0] wr_data,
  output logic              freq_load,
  output logic [FREQ_W-1:0] freq_word,
  output logic              loop_en,
  output logic              seq_err
);
  cnt_t cnt_after;

  lcs_ms_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cyc_start), .tick(ms_tick),
    .cnt_after(cnt_after)
  );

  lcs_freq_buffer #(.W(FREQ_W)) u_freq (
    .clk(clk), .rst_n(rst_n), .wr(wr_en && !wr_sel), .wdata(wr_data),
    .swap(cyc_start), .active(freq_word)
  );

  lcs_close_ctrl #(.W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_end(cyc_end),
    .cal_stop(cal_stop), .tick(ms_tick), .cnt_after(cnt_after),
    .ct_wr(wr_en && wr_sel), .ct_wdata(wr_data[CNT_W-1:0]),
    .load_pulse(freq_load), .loop_en(loop_en), .err(seq_err)
  );
endmodule

// File: rtl/loop_close_seq_chk.sv
module loop_close_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ms_tick,
  input logic        cyc_start,
  input logic        cal_stop,
  input logic        cyc_end,
  input logic        freq_load,
  input logic [31:0] freq_word,
  input logic        loop_en,
  input logic        seq_err
);
  // R3
  load_after_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freq_load |-> $past(cal_stop));
  // R5
  close_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_en) |-> $past(ms_tick));
  // R7
  open_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> !loop_en);
  // R7
  open_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !loop_en);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);
  // R9
  word_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_word) |-> $past(cyc_start));
endmodule

bind loop_close_seq loop_close_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cyc_start(cyc_start),
  .cal_stop(cal_stop), .cyc_end(cyc_end), .freq_load(freq_load),
  .freq_word(freq_word), .loop_en(loop_en), .seq_err(seq_err)
);

// File: tb/loop_close_seq_test.sv
module loop_close_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0, cyc_start = 1'b0, cal_stop = 1'b0, cyc_end = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic freq_load, loop_en, seq_err;
  logic [31:0] freq_word;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  loop_close_seq uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cyc_start(cyc_start),
    .cal_stop(cal_stop), .cyc_end(cyc_end), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .freq_load(freq_load), .freq_word(freq_word),
    .loop_en(loop_en), .seq_err(seq_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic p_start(); cyc_start = 1; step(); cyc_start = 0; endtask
  task automatic p_end();   cyc_end   = 1; step(); cyc_end   = 0; endtask
  task automatic p_cal();   cal_stop  = 1; step(); cal_stop  = 0; endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1; step(); ms_tick = 0; step(); step();
    end
  endtask
  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d; step(); wr_en = 0;
  endtask

  task automatic t_reset();
    chk("R1 loop_en", {31'b0, loop_en}, 0);
    chk("R1 freq_load", {31'b0, freq_load}, 0);
    chk("R1 seq_err", {31'b0, seq_err}, 0);
    chk("R1 freq_word", freq_word, 0);
  endtask

  task automatic t_normal();
    wr(0, 32'hA5A5_1234);
    wr(1, 5);
    chk("R9 word before start", freq_word, 0);
    p_start();
    chk("R9 word after start", freq_word, 32'hA5A5_1234);
    p_cal();
    chk("R3 load pulse", {31'b0, freq_load}, 1);
    chk("R3 loop open at load", {31'b0, loop_en}, 0);
    step();
    chk("R3 pulse one clock", {31'b0, freq_load}, 0);
    ticks(4);
    chk("R5 open before match", {31'b0, loop_en}, 0);
    ticks(1);
    chk("R5 closed at match", {31'b0, loop_en}, 1);
    ticks(3);
    chk("R5 stays closed", {31'b0, loop_en}, 1);
    chk("R8 no error", {31'b0, seq_err}, 0);
    p_end();
    chk("R7 open at end", {31'b0, loop_en}, 0);
  endtask

  task automatic t_outside();
    p_cal();
    chk("R4 cal outside cycle", {31'b0, freq_load}, 0);
    wr(1, 10);
    ticks(2);
    chk("R6 no match outside cycle", {31'b0, loop_en}, 0);
  endtask

  task automatic t_error_once();
    p_start();
    wr(1, 3);
    ticks(3);
    chk("R8 loop open without load", {31'b0, loop_en}, 0);
    chk("R8 error set", {31'b0, seq_err}, 1);
    p_cal();
    chk("R3 late load pulse", {31'b0, freq_load}, 1);
    step();
    p_cal();
    chk("R4 second cal ignored", {31'b0, freq_load}, 0);
    wr(1, 5);
    ticks(2);
    chk("R6 single match per cycle", {31'b0, loop_en}, 0);
    chk("R8 error sticky", {31'b0, seq_err}, 1);
  endtask

  task automatic t_restart();
    wr(0, 32'h0BAD_F00D);
    chk("R9 staged not applied", freq_word, 32'hA5A5_1234);
    p_start();
    chk("R9 staged applied", freq_word, 32'h0BAD_F00D);
    wr(1, 4);
    p_cal();
    step();
    ticks(4);
    chk("R10 new close time", {31'b0, loop_en}, 1);
    p_start();
    chk("R7 open at start", {31'b0, loop_en}, 0);
    p_cal();
    step();
    ticks(3);
    chk("R2 count restarted", {31'b0, loop_en}, 0);
    ticks(1);
    chk("R2 match after restart", {31'b0, loop_en}, 1);
    chk("R8 error still sticky", {31'b0, seq_err}, 1);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_normal();
    t_outside();
    t_error_once();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule